// File: doc/BRIEF.md
# Configuration-Space Indirect Register Window

This block gives a host a path into a device's memory-mapped register bank through configuration cycles alone, with no need to map the BAR. The host first programs three fields: a BAR selector, an access length in bytes and a byte offset. It then reads or writes a 32-bit data window. A window write first merges the written bytes into the window. The block then pushes the window contents into the register bank. A window read first fetches from the register bank into the window, and then returns the window.

The access forwarded to the bank always takes its width from the programmed length field. The byte enables of the configuration access that triggers it play no part in that width. A window access goes ahead only if the programmed fields describe a legal access to the single BAR. Otherwise the bank is left alone and the response carries an error flag. The field registers accept any value at write time, so the host may pass through illegal combinations while it reprograms them.

The configuration request port is valid/ready. The block lowers `cfg_req_ready` from the cycle after it accepts a request until it has sent the response. The response is a single-cycle `cfg_rsp_valid` pulse and cannot be back-pressured. The bank request is also valid/ready. Once raised, `bank_req_valid` and its payload hold steady until the bank raises `bank_req_ready`. For a read, `bank_rsp_rdata` is sampled in that handshake cycle.

Top module: `cfgwin_bridge`

## Requirements
- R1: The block decodes four dword indices: CAP_BASE+0 is the BAR selector in bits 7:0, CAP_BASE+1 is the length, CAP_BASE+2 is the offset and CAP_BASE+3 is the window. A write to a field index merges the bytes whose byte enable is set, with no validation. A read returns the stored field.
- R2: A window access is legal only when all of these hold: the selector is 0, the length is 1, 2 or 4, the offset is a multiple of the length, and offset plus length does not exceed BAR_SIZE.
- R3: A legal window write merges the enabled bytes of the write data into the window. It then issues exactly one bank write at the offset, with the window as data. Its response has the error flag clear and read data 0.
- R4: The bank byte mask has bit i set for each i below the length, giving 0001, 0011 or 1111. It does not depend on the configuration byte enables.
- R5: A legal window read issues exactly one bank read at the offset. The window is loaded with the bank data, with bytes at or above the length cleared. The response returns the window with bytes whose enable is clear forced to 0.
- R6: An illegal window write sets the response error flag and issues no bank request. The window keeps its old value.
- R7: An illegal window read sets the response error flag and issues no bank request. It returns the unchanged window, masked by the byte enables.
- R8: A write to any other index is acknowledged without error and changes no field and no window. A read of any other index returns 0.
- R9: `cfg_req_ready` is low while a bank request is outstanding. An unaccepted bank request keeps its valid and payload stable.
- R10: After reset the three fields and the window are 0, and `cfg_rsp_valid` and `bank_req_valid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_req_valid | input | 1 | Configuration request valid |
| cfg_req_ready | output | 1 | Configuration request accepted when high with valid |
| cfg_req_write | input | 1 | 1 = write, 0 = read |
| cfg_req_index | input | IDX_W | Dword register index |
| cfg_req_be | input | 4 | Byte enables |
| cfg_req_wdata | input | 32 | Write data |
| cfg_rsp_valid | output | 1 | One-cycle response pulse |
| cfg_rsp_rdata | output | 32 | Read data (0 for writes) |
| cfg_rsp_err | output | 1 | Illegal window access |
| bank_req_valid | output | 1 | Bank request valid |
| bank_req_ready | input | 1 | Bank accepts request |
| bank_req_write | output | 1 | 1 = bank write, 0 = bank read |
| bank_req_offset | output | OFF_W | Byte offset within the BAR |
| bank_req_mask | output | 4 | Byte mask, derived from the length |
| bank_req_wdata | output | 32 | Bank write data |
| bank_rsp_rdata | input | 32 | Bank read data, valid in the read handshake cycle |

## Verification
The bench builds the block with BAR_SIZE=16, IDX_W=4 and CAP_BASE=4. A 4-bit index makes all sixteen dword indices reachable, so every non-capability index can be probed. A 16-byte BAR makes it feasible to sweep every selector of 0 and 1, every length from 0 to 5 and every offset from 0 to 17. That sweep covers each alignment case and each case that runs past the end of the BAR, including the exact-fit corner. A pseudo-random bank ready pattern stalls the bank handshake throughout the sweep.

// File: rtl/cfgwin_pkg.sv
package cfgwin_pkg;

  typedef enum logic {ST_IDLE, ST_BANK} bw_state_t;

  function automatic logic [31:0] be_bits(input logic [3:0] be);
    return {{8{be[3]}}, {8{be[2]}}, {8{be[1]}}, {8{be[0]}}};
  endfunction

  function automatic logic [31:0] be_merge(input logic [31:0] old_v,
                                           input logic [31:0] new_v,
                                           input logic [3:0]  be);
    return (old_v & ~be_bits(be)) | (new_v & be_bits(be));
  endfunction

endpackage

// File: rtl/cfgwin_check.sv
module cfgwin_check #(
  parameter int BAR_SIZE = 4096
) (
  input  logic [7:0]  bar_sel,
  input  logic [31:0] len,
  input  logic [31:0] off,
  output logic        legal,
  output logic [3:0]  lmask
);
  localparam logic [32:0] SIZE33 = 33'(BAR_SIZE);

  logic        len_ok;
  logic        aligned;
  logic        in_range;
  logic [32:0] end_pos;

  always_comb begin
    len_ok  = 1'b0;
    aligned = 1'b0;
    lmask   = 4'b0000;
    case (len)
      32'd1: begin len_ok = 1'b1; aligned = 1'b1;           lmask = 4'b0001; end
      32'd2: begin len_ok = 1'b1; aligned = ~off[0];        lmask = 4'b0011; end
      32'd4: begin len_ok = 1'b1; aligned = (off[1:0] == 2'b00); lmask = 4'b1111; end
      default: ;
    endcase
    end_pos  = {1'b0, off} + {1'b0, len};
    in_range = (end_pos <= SIZE33);
    legal    = (bar_sel == 8'd0) && len_ok && aligned && in_range;
  end
endmodule

// File: rtl/cfgwin_regs.sv
module cfgwin_regs
  import cfgwin_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        fld_we,
  input  logic [1:0]  fld_sel,
  input  logic [3:0]  be,
  input  logic [31:0] wdata,
  input  logic        win_merge,
  input  logic        win_load,
  input  logic [31:0] win_load_data,
  output logic [7:0]  bar_q,
  output logic [31:0] len_q,
  output logic [31:0] off_q,
  output logic [31:0] win_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bar_q <= '0;
      len_q <= '0;
      off_q <= '0;
      win_q <= '0;
    end else begin
      if (fld_we) begin
        case (fld_sel)
          2'd0:    if (be[0]) bar_q <= wdata[7:0];
          2'd1:    len_q <= be_merge(len_q, wdata, be);
          default: off_q <= be_merge(off_q, wdata, be);
        endcase
      end
      if (win_merge)
        win_q <= be_merge(win_q, wdata, be);
      else if (win_load)
        win_q <= win_load_data;
    end
  end
endmodule

// File: rtl/cfgwin_fsm.sv
module cfgwin_fsm
  import cfgwin_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        acc,
  input  logic        is_win,
  input  logic        is_write,
  input  logic        legal,
  input  logic [3:0]  be,
  input  logic [31:0] imm_rdata,
  input  logic [31:0] win_q,
  input  logic [3:0]  lmask,
  input  logic        bank_ready,
  input  logic [31:0] bank_rdata,
  output logic        req_ready,
  output logic        bank_valid,
  output logic        bank_write,
  output logic        win_load,
  output logic        rsp_valid,
  output logic [31:0] rsp_rdata,
  output logic        rsp_err
);
  bw_state_t  state;
  logic       wr_q;
  logic [3:0] be_q;

  assign req_ready  = (state == ST_IDLE);
  assign bank_valid = (state == ST_BANK);
  assign bank_write = wr_q;
  assign win_load   = (state == ST_BANK) && bank_ready && !wr_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      wr_q      <= 1'b0;
      be_q      <= '0;
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
      rsp_err   <= 1'b0;
    end else begin
      rsp_valid <= 1'b0;
      case (state)
        ST_IDLE: if (acc) begin
          if (is_win && legal) begin
            state <= ST_BANK;
            wr_q  <= is_write;
            be_q  <= be;
          end else begin
            rsp_valid <= 1'b1;
            rsp_err   <= is_win;
            rsp_rdata <= is_write ? 32'd0
                       : ((is_win ? win_q : imm_rdata) & be_bits(be));
          end
        end
        default: if (bank_ready) begin
          state     <= ST_IDLE;
          rsp_valid <= 1'b1;
          rsp_err   <= 1'b0;
          rsp_rdata <= wr_q ? 32'd0
                     : (bank_rdata & be_bits(lmask) & be_bits(be_q));
        end
      endcase
    end
  end

  assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    bank_valid && !bank_ready |=> bank_valid && $stable(wr_q));
  assert_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
    bank_valid |-> !req_ready);
endmodule

// File: rtl/cfgwin_bridge.sv
module cfgwin_bridge
  import cfgwin_pkg::*;
#(
  parameter int BAR_SIZE = 4096,
  parameter int IDX_W    = 10,
  parameter int CAP_BASE = 16,
  localparam int OFF_W   = $clog2(BAR_SIZE)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_req_valid,
  output logic             cfg_req_ready,
  input  logic             cfg_req_write,
  input  logic [IDX_W-1:0] cfg_req_index,
  input  logic [3:0]       cfg_req_be,
  input  logic [31:0]      cfg_req_wdata,
  output logic             cfg_rsp_valid,
  output logic [31:0]      cfg_rsp_rdata,
  output logic             cfg_rsp_err,
  output logic             bank_req_valid,
  input  logic             bank_req_ready,
  output logic             bank_req_write,
  output logic [OFF_W-1:0] bank_req_offset,
  output logic [3:0]       bank_req_mask,
  output logic [31:0]      bank_req_wdata,
  input  logic [31:0]      bank_rsp_rdata
);
  localparam logic [IDX_W-1:0] IDX_BAR = IDX_W'(CAP_BASE);
  localparam logic [IDX_W-1:0] IDX_LEN = IDX_W'(CAP_BASE + 1);
  localparam logic [IDX_W-1:0] IDX_OFF = IDX_W'(CAP_BASE + 2);
  localparam logic [IDX_W-1:0] IDX_WIN = IDX_W'(CAP_BASE + 3);
  localparam logic [32:0]      SIZE33  = 33'(BAR_SIZE);

  logic        acc, is_win, is_fld, legal, win_load;
  logic [1:0]  fld_sel;
  logic [3:0]  lmask;
  logic [7:0]  bar_q;
  logic [31:0] len_q, off_q, win_q, imm_rdata;

  assign acc    = cfg_req_valid && cfg_req_ready;
  assign is_win = (cfg_req_index == IDX_WIN);

  always_comb begin
    is_fld    = 1'b1;
    fld_sel   = 2'd0;
    imm_rdata = 32'd0;
    if (cfg_req_index == IDX_BAR)      begin fld_sel = 2'd0; imm_rdata = {24'd0, bar_q}; end
    else if (cfg_req_index == IDX_LEN) begin fld_sel = 2'd1; imm_rdata = len_q; end
    else if (cfg_req_index == IDX_OFF) begin fld_sel = 2'd2; imm_rdata = off_q; end
    else is_fld = 1'b0;
  end

  cfgwin_check #(.BAR_SIZE(BAR_SIZE)) u_check (
    .bar_sel(bar_q), .len(len_q), .off(off_q), .legal(legal), .lmask(lmask)
  );

  cfgwin_regs u_regs (
    .clk(clk), .rst_n(rst_n),
    .fld_we(acc && cfg_req_write && is_fld), .fld_sel(fld_sel),
    .be(cfg_req_be), .wdata(cfg_req_wdata),
    .win_merge(acc && cfg_req_write && is_win && legal),
    .win_load(win_load), .win_load_data(bank_rsp_rdata & be_bits(lmask)),
    .bar_q(bar_q), .len_q(len_q), .off_q(off_q), .win_q(win_q)
  );

  cfgwin_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .acc(acc), .is_win(is_win),
    .is_write(cfg_req_write), .legal(legal), .be(cfg_req_be),
    .imm_rdata(imm_rdata), .win_q(win_q), .lmask(lmask),
    .bank_ready(bank_req_ready), .bank_rdata(bank_rsp_rdata),
    .req_ready(cfg_req_ready), .bank_valid(bank_req_valid),
    .bank_write(bank_req_write), .win_load(win_load),
    .rsp_valid(cfg_rsp_valid), .rsp_rdata(cfg_rsp_rdata), .rsp_err(cfg_rsp_err)
  );

  assign bank_req_offset = off_q[OFF_W-1:0];
  assign bank_req_mask   = lmask;
  assign bank_req_wdata  = win_q;

  assert_legal_R2: assert property (@(posedge clk) disable iff (!rst_n)
    bank_req_valid |-> (bar_q == 8'd0) &&
      (({1'b0, off_q} + 33'($countones(bank_req_mask))) <= SIZE33));
  assert_mask_R4: assert property (@(posedge clk) disable iff (!rst_n)
    bank_req_valid |-> (bank_req_mask == 4'b0001 || bank_req_mask == 4'b0011 ||
                        bank_req_mask == 4'b1111));
  assert_err_nobank_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_rsp_valid && cfg_rsp_err |-> !$past(bank_req_valid));
  assert_stable_R9: assert property (@(posedge clk) disable iff (!rst_n)
    bank_req_valid && !bank_req_ready |=>
      $stable(bank_req_offset) && $stable(bank_req_mask) && $stable(bank_req_wdata));
endmodule

// File: tb/cfgwin_bridge_tb.sv
module cfgwin_bridge_tb;
  localparam int BAR_SIZE = 16;
  localparam int IDX_W    = 4;
  localparam int CAP_BASE = 4;
  localparam int OFF_W    = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic             cfg_req_valid = 1'b0, cfg_req_write = 1'b0;
  logic             cfg_req_ready, cfg_rsp_valid, cfg_rsp_err;
  logic [IDX_W-1:0] cfg_req_index = '0;
  logic [3:0]       cfg_req_be = '0;
  logic [31:0]      cfg_req_wdata = '0, cfg_rsp_rdata;
  logic             bank_req_valid, bank_req_write;
  logic             bank_req_ready = 1'b0;
  logic [OFF_W-1:0] bank_req_offset;
  logic [3:0]       bank_req_mask;
  logic [31:0]      bank_req_wdata, bank_rsp_rdata;

  cfgwin_bridge #(.BAR_SIZE(BAR_SIZE), .IDX_W(IDX_W), .CAP_BASE(CAP_BASE)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .cfg_req_valid(cfg_req_valid), .cfg_req_ready(cfg_req_ready),
    .cfg_req_write(cfg_req_write), .cfg_req_index(cfg_req_index),
    .cfg_req_be(cfg_req_be), .cfg_req_wdata(cfg_req_wdata),
    .cfg_rsp_valid(cfg_rsp_valid), .cfg_rsp_rdata(cfg_rsp_rdata),
    .cfg_rsp_err(cfg_rsp_err),
    .bank_req_valid(bank_req_valid), .bank_req_ready(bank_req_ready),
    .bank_req_write(bank_req_write), .bank_req_offset(bank_req_offset),
    .bank_req_mask(bank_req_mask), .bank_req_wdata(bank_req_wdata),
    .bank_rsp_rdata(bank_rsp_rdata)
  );

  int errors = 0, checks = 0;
  logic [7:0] mem [BAR_SIZE];
  logic [7:0] ref_mem [BAR_SIZE];
  logic [31:0] ref_win = '0;
  int n_wr = 0, n_rd = 0;
  logic [OFF_W-1:0] last_off;
  logic [3:0]  last_mask;
  logic [31:0] last_data;
  logic [7:0]  lfsr = 8'h5A;

  always_comb begin
    bank_rsp_rdata = '0;
    for (int i = 0; i < 4; i++)
      if (int'(bank_req_offset) + i < BAR_SIZE)
        bank_rsp_rdata[8*i +: 8] = mem[int'(bank_req_offset) + i];
  end

  always @(posedge clk) begin
    if (bank_req_valid && bank_req_ready) begin
      if (bank_req_write) begin
        n_wr <= n_wr + 1;
        last_off <= bank_req_offset; last_mask <= bank_req_mask; last_data <= bank_req_wdata;
        for (int i = 0; i < 4; i++)
          if (bank_req_mask[i] && int'(bank_req_offset) + i < BAR_SIZE)
            mem[int'(bank_req_offset) + i] <= bank_req_wdata[8*i +: 8];
      end else n_rd <= n_rd + 1;
    end
  end

  always @(negedge clk) begin
    lfsr <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    bank_req_ready <= lfsr[0] | lfsr[2];
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] bm(input logic [3:0] be);
    return {{8{be[3]}}, {8{be[2]}}, {8{be[1]}}, {8{be[0]}}};
  endfunction

  logic [31:0] r_data;
  logic        r_err;

  task automatic cfg_op(input logic wr, input int idx, input logic [3:0] be,
                        input logic [31:0] wd);
    int t;
    @(negedge clk);
    cfg_req_valid = 1'b1; cfg_req_write = wr; cfg_req_index = IDX_W'(idx);
    cfg_req_be = be; cfg_req_wdata = wd;
    while (!cfg_req_ready) @(negedge clk);
    @(negedge clk);
    cfg_req_valid = 1'b0;
    t = 0;
    while (!cfg_rsp_valid && t < 100) begin @(negedge clk); t++; end
    if (t >= 100) begin r_data = 'x; r_err = 1'bx; end
    else begin r_data = cfg_rsp_rdata; r_err = cfg_rsp_err; end
  endtask

  initial begin
    repeat (400000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int w0, r0;
    logic ok;
    logic [3:0] be, lm;
    logic [31:0] d, exp;
    for (int i = 0; i < BAR_SIZE; i++) begin mem[i] = 8'(i * 37 + 11); ref_mem[i] = 8'(i * 37 + 11); end
    repeat (3) @(negedge clk);
    // R10 reset state
    check("R10 rsp_valid", {31'd0, cfg_rsp_valid}, 32'd0);
    check("R10 bank_valid", {31'd0, bank_req_valid}, 32'd0);
    rst_n = 1'b1;
    for (int f = 0; f < 3; f++) begin
      cfg_op(1'b0, CAP_BASE + f, 4'hF, 0);
      check("R10 field zero", r_data, 32'd0);
    end
    cfg_op(1'b0, CAP_BASE + 3, 4'hF, 0);
    check("R10 window zero", r_data, 32'd0);
    check("R7 err at reset", {31'd0, r_err}, 32'd1);

    // R1 byte-enable merge on fields
    cfg_op(1'b1, CAP_BASE + 2, 4'hF, 32'h1122_3344);
    cfg_op(1'b1, CAP_BASE + 2, 4'b0101, 32'hAABB_CCDD);
    cfg_op(1'b0, CAP_BASE + 2, 4'hF, 0);
    check("R1 offset merge", r_data, 32'h11BB_33DD);
    cfg_op(1'b1, CAP_BASE, 4'hF, 32'hFFFF_FF7E);
    cfg_op(1'b0, CAP_BASE, 4'hF, 0);
    check("R1 bar byte0 only", r_data, 32'h0000_007E);

    // R8 other indices
    for (int idx = 0; idx < 16; idx++) begin
      if (idx >= CAP_BASE && idx < CAP_BASE + 4) continue;
      w0 = n_wr;
      cfg_op(1'b1, idx, 4'hF, 32'hDEAD_BEEF);
      check("R8 write no err", {31'd0, r_err}, 32'd0);
      cfg_op(1'b0, idx, 4'hF, 0);
      check("R8 read zero", r_data, 32'd0);
      check("R8 no bank write", n_wr - w0, 0);
    end
    cfg_op(1'b0, CAP_BASE + 2, 4'hF, 0);
    check("R8 offset untouched", r_data, 32'h11BB_33DD);

    // Sweep selector/length/offset
    for (int b = 0; b < 2; b++)
      for (int l = 0; l < 6; l++)
        for (int o = 0; o < 18; o++) begin
          cfg_op(1'b1, CAP_BASE, 4'hF, b);
          cfg_op(1'b1, CAP_BASE + 1, 4'hF, l);
          cfg_op(1'b1, CAP_BASE + 2, 4'hF, o);
          cfg_op(1'b0, CAP_BASE + 1, 4'hF, 0);
          check("R1 len readback", r_data, 32'(l));
          ok = (b == 0) && (l == 1 || l == 2 || l == 4) && (o % (l == 0 ? 1 : l) == 0)
               && (o + l <= BAR_SIZE);
          lm = (l == 1) ? 4'b0001 : (l == 2) ? 4'b0011 : (l == 4) ? 4'b1111 : 4'b0000;
          be = 4'((o * 7 + l * 3 + b) % 15 + 1);
          d  = {8'(o * 13 + 1), 8'(l * 29 + 2), 8'(b * 71 + o + 3), 8'(o + l * 5 + 4)};
          w0 = n_wr; r0 = n_rd;
          cfg_op(1'b1, CAP_BASE + 3, be, d);
          if (ok) begin
            ref_win = (ref_win & ~bm(be)) | (d & bm(be));
            check("R3 write no err", {31'd0, r_err}, 32'd0);
            check("R3 one bank write", n_wr - w0, 1);
            check("R3 bank offset", {28'd0, last_off}, 32'(o));
            check("R4 bank mask", {28'd0, last_mask}, {28'd0, lm});
            check("R3 bank data", last_data, ref_win);
            for (int i = 0; i < 4; i++)
              if (lm[i]) ref_mem[o + i] = ref_win[8*i +: 8];
          end else begin
            check("R6 write err", {31'd0, r_err}, 32'd1);
            check("R6 no bank access", (n_wr - w0) + (n_rd - r0), 0);
          end
          be = ~be | 4'b0001;
          w0 = n_wr; r0 = n_rd;
          cfg_op(1'b0, CAP_BASE + 3, be, 0);
          if (ok) begin
            ref_win = '0;
            for (int i = 0; i < 4; i++)
              if (lm[i]) ref_win[8*i +: 8] = ref_mem[o + i];
            check("R5 read no err", {31'd0, r_err}, 32'd0);
            check("R5 one bank read", (n_rd - r0) * 16 + (n_wr - w0), 16);
          end else begin
            check("R7 read err", {31'd0, r_err}, 32'd1);
            check("R7 no bank access", (n_wr - w0) + (n_rd - r0), 0);
          end
          exp = ref_win & bm(be);
          check(ok ? "R5 read data" : "R7 stale window", r_data, exp);
          cfg_op(1'b0, CAP_BASE + 3, 4'hF, 0);
          check(ok ? "R5 window reload" : "R6 window unchanged", r_data, ref_win);
        end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule